// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge

This block connects an internal bus (16-bit address, 8-bit data, one request per bus cycle) to an external bus that uses few pins. The high address byte goes out on one 8-bit port. A second 8-bit port is shared: it first carries the low address byte and then the data byte. A strobe output goes high early in each cycle so that an external transparent latch can hold the low address byte. A read/write line and a data-phase clock complete the external control.

When the expanded-mode enable is high, bus cycles run back to back. Each cycle lasts `2*PHASE_LEN` clocks and is split into an address phase and a data phase of `PHASE_LEN` clocks each. The request inputs are sampled on the clock edge that starts a cycle. On a read, the shared port is released during the data phase. The byte on it is captured at the end of the cycle and appears on `rdData`, with a one-clock `rdValid` pulse. When the enable is low, the block drives nothing and the strobe stays low.

Top module: `mux_bus_bridge`

## Requirements
- R1: While reset is high and after it, until a cycle starts: `asOut`=0, `eClkOut`=0, `portBOe`=0, `portCOe`=0, `rwOut`=1 and `rdValid`=0.
- R2: A bus cycle lasts exactly 2*PHASE_LEN clocks. `asOut` is high only in the first PHASE_LEN-1 clocks of a cycle, and it falls while the low address byte is still being driven.
- R3: During every clock of a cycle, `portBOe`=1 and `portBOut` holds bits 15:8 of the sampled address.
- R4: During the address phase (the first PHASE_LEN clocks), `portCOe`=1 and `portCOut` holds bits 7:0 of the sampled address.
- R5: On a write, during the data phase (the last PHASE_LEN clocks), `eClkOut`=1, `portCOe`=1 and `portCOut` holds the sampled write data.
- R6: On a read, `portCOe`=0 during the data phase. `portCIn` is sampled at the clock edge that ends the cycle. It then appears on `rdData` with `rdValid`=1 for exactly one clock. `rdValid` stays 0 after a write cycle.
- R7: `rwOut`=0 for a write cycle and 1 for a read cycle. It is constant through the whole cycle and is 1 when the bus is idle.
- R8: If `expEn` is low at a clock edge, the next clock is idle (as in R1) and any cycle in flight is dropped without its data phase or capture. Raising `expEn` starts a cycle at the next edge.
- R9: `reqAddr`, `reqWdata` and `reqWrite` are sampled only on the edge that starts a cycle. Changing them during a cycle does not change that cycle's port values.
- R10: With `expEn` held high, cycles follow each other with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| expEn | input | 1 | Expanded-mode enable |
| reqAddr | input | 16 | Internal address for the next cycle |
| reqWdata | input | 8 | Write data for the next cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| portCIn | input | 8 | Shared port input (read data from the external bus) |
| portBOut | output | 8 | High address byte drive value |
| portBOe | output | 1 | High address port output enable |
| portCOut | output | 8 | Shared port drive value (low address, then write data) |
| portCOe | output | 1 | Shared port output enable |
| asOut | output | 1 | Address strobe for the external latch |
| eClkOut | output | 1 | High during the data phase |
| rwOut | output | 1 | Read/write line, 0 = write |
| rdData | output | 8 | Captured read byte |
| rdValid | output | 1 | One-clock pulse when `rdData` is updated |

## Verification
The bench uses an external latch model, which the strobe opens, and a memory model addressed through the latched byte and the high port. Directed back-to-back writes to all-zero, all-one and mixed-byte addresses, followed by reads, show whether the high and low bytes are swapped or mixed up. A write dropped when the enable falls mid-cycle must leave the memory unchanged. A mid-cycle change of the request inputs separates sampling at the cycle start from passing the inputs straight through. Random interleaved reads and writes with a fixed seed then check read data against a reference memory. This shows whether the capture edge and the release of the shared port are placed correctly.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef struct packed {
    logic load;       // sample request on this edge
    logic capture;    // sample shared port on this edge
    logic busOn;      // a cycle is in progress
    logic addrPhase;  // shared port carries low address
    logic asOn;       // strobe high
    logic dataPhase;  // shared port carries data
  } mbbStrobes_t;
endpackage

// File: rtl/mbb_ctrl.sv
module mbb_ctrl #(
  parameter int PHASE_LEN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                expEn,
  output mbb_pkg::mbbStrobes_t strobes
);
  localparam int CYC = 2 * PHASE_LEN;
  localparam int CW  = $clog2(CYC);

  logic          running;
  logic [CW-1:0] cnt;
  logic          lastClk;

  assign lastClk = running && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !expEn) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running || lastClk) begin
      running <= 1'b1;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobes.load      = expEn && (!running || lastClk);
    strobes.capture   = expEn && lastClk;
    strobes.busOn     = running;
    strobes.addrPhase = running && (cnt < CW'(PHASE_LEN));
    strobes.asOn      = running && (cnt < CW'(PHASE_LEN - 1));
    strobes.dataPhase = running && (cnt >= CW'(PHASE_LEN));
  end
endmodule

// File: rtl/mbb_datapath.sv
module mbb_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mbb_pkg::mbbStrobes_t strobes,
  input  logic [2*DATA_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    portCIn,
  output logic [DATA_W-1:0]    portBOut,
  output logic                 portBOe,
  output logic [DATA_W-1:0]    portCOut,
  output logic                 portCOe,
  output logic                 asOut,
  output logic                 eClkOut,
  output logic                 rwOut,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curData;
  logic              curWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr  <= '0;
      curData  <= '0;
      curWrite <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobes.load) begin
        curAddr  <= reqAddr;
        curData  <= reqWdata;
        curWrite <= reqWrite;
      end
      rdValid <= strobes.capture && !curWrite;
      if (strobes.capture && !curWrite) rdData <= portCIn;
    end
  end

  always_comb begin
    portBOe  = strobes.busOn;
    portBOut = strobes.busOn ? curAddr[ADDR_W-1:DATA_W] : '0;
    portCOe  = strobes.addrPhase || (strobes.dataPhase && curWrite);
    if (strobes.addrPhase)                  portCOut = curAddr[DATA_W-1:0];
    else if (strobes.dataPhase && curWrite) portCOut = curData;
    else                                    portCOut = '0;
    asOut   = strobes.asOn;
    eClkOut = strobes.dataPhase;
    rwOut   = !(strobes.busOn && curWrite);
  end
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge #(
  parameter int DATA_W    = 8,
  parameter int PHASE_LEN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                expEn,
  input  logic [2*DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   portCIn,
  output logic [DATA_W-1:0]   portBOut,
  output logic                portBOe,
  output logic [DATA_W-1:0]   portCOut,
  output logic                portCOe,
  output logic                asOut,
  output logic                eClkOut,
  output logic                rwOut,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid
);
  mbb_pkg::mbbStrobes_t strobes;

  mbb_ctrl #(.PHASE_LEN(PHASE_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .expEn(expEn), .strobes(strobes)
  );

  mbb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqWrite(reqWrite),
    .portCIn(portCIn),
    .portBOut(portBOut), .portBOe(portBOe),
    .portCOut(portCOut), .portCOe(portCOe),
    .asOut(asOut), .eClkOut(eClkOut), .rwOut(rwOut),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/mbb_checker.sv
module mbb_checker #(
  parameter int DATA_W    = 8,
  parameter int PHASE_LEN = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              expEn,
  input logic [DATA_W-1:0] portBOut,
  input logic              portBOe,
  input logic              portCOe,
  input logic              asOut,
  input logic              eClkOut,
  input logic              rwOut,
  input logic              rdValid
);
  localparam int CYC = 2 * PHASE_LEN;
  localparam int PW  = $clog2(CYC + 1) + 1;

  logic          asQ;
  logic          asSeen;
  logic [PW-1:0] posCnt;

  always_ff @(posedge clk) begin
    if (rst || !portBOe) begin
      asQ    <= 1'b0;
      asSeen <= 1'b0;
      posCnt <= '0;
    end else begin
      asQ <= asOut;
      if (asOut && !asQ) begin
        asSeen <= 1'b1;
        posCnt <= PW'(1);
      end else if (posCnt <= PW'(CYC)) begin
        posCnt <= posCnt + 1'b1;
      end
    end
  end

  // R2 / R10: consecutive strobe starts are exactly one cycle length apart
  p_cycle_len_r2: assert property (@(posedge clk) disable iff (rst)
    (portBOe && asOut && !asQ && asSeen) |-> (posCnt == PW'(CYC)));

  p_as_fall_addr_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(asOut) && portBOe |-> (portCOe && !eClkOut));

  p_addr_hi_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (portBOe && $past(portBOe) && !$rose(asOut)) |-> $stable(portBOut));

  p_strobe_drive_r4: assert property (@(posedge clk) disable iff (rst)
    asOut |-> (portBOe && portCOe && !eClkOut));

  p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
    (eClkOut && rwOut) |-> !portCOe);

  p_rdvalid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  p_rw_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (portBOe && $past(portBOe) && !$rose(asOut)) |-> $stable(rwOut));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !expEn |=> (!asOut && !portBOe && !portCOe && rwOut && !eClkOut));
endmodule

bind mux_bus_bridge mbb_checker #(.DATA_W(DATA_W), .PHASE_LEN(PHASE_LEN)) u_chk (
  .clk(clk), .rst(rst), .expEn(expEn), .portBOut(portBOut), .portBOe(portBOe),
  .portCOe(portCOe), .asOut(asOut), .eClkOut(eClkOut), .rwOut(rwOut),
  .rdValid(rdValid)
);

// File: tb/mux_bus_bridge_tb.sv
module mux_bus_bridge_tb;
  localparam int PL  = 2;
  localparam int CYC = 2 * PL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        expEn = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqWrite = 1'b0;
  logic [7:0]  portCIn;
  logic [7:0]  portBOut, portCOut, rdData;
  logic        portBOe, portCOe, asOut, eClkOut, rwOut, rdValid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mux_bus_bridge #(.DATA_W(8), .PHASE_LEN(PL)) u_dut (
    .clk(clk), .rst(rst), .expEn(expEn), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqWrite(reqWrite), .portCIn(portCIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCOut(portCOut), .portCOe(portCOe), .asOut(asOut), .eClkOut(eClkOut),
    .rwOut(rwOut), .rdData(rdData), .rdValid(rdValid)
  );

  // external transparent latch and memory models
  logic [7:0] latchLo = '0;
  logic [7:0] mem    [0:1023];
  logic [7:0] refMem [0:1023];

  function automatic int idx(input logic [15:0] a);
    return int'({a[15] ^ a[9], a[8], a[7:0]});
  endfunction

  always_latch if (asOut) latchLo = portCOut;
  assign portCIn = (eClkOut && rwOut) ? mem[idx({portBOut, latchLo})] : 8'h00;

  always @(posedge clk)
    if (eClkOut && !rwOut && portCOe) mem[idx({portBOut, latchLo})] <= portCOut;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  bit         pendRead = 0;
  logic [7:0] pendVal  = '0;

  task automatic idleCheck(input string tag);
    check(!asOut && !eClkOut && !portBOe && !portCOe && rwOut && !rdValid, tag,
          {asOut, eClkOut, portBOe, portCOe, rwOut, rdValid}, 6'b000010);
  endtask

  // precondition: at a negedge just before a cycle-start edge
  task automatic busCycle(input bit w, input logic [15:0] a, input logic [7:0] d);
    logic [7:0] expRd;
    expRd    = refMem[idx(a)];
    reqWrite = w; reqAddr = a; reqWdata = d;
    for (int p = 0; p < CYC; p++) begin
      @(negedge clk);
      if (p == 0) begin
        if (pendRead) check(rdValid && rdData == pendVal, "R6 read data", rdData, pendVal);
        else          check(!rdValid, "R6 no rdValid after write", rdValid, 0);
      end
      if (p == 1) begin // R9: disturb inputs mid-cycle
        reqAddr = ~a; reqWdata = ~d; reqWrite = ~w;
      end
      check(asOut == (p < PL - 1), "R2 strobe window", asOut, p < PL - 1);
      check(portBOe && portBOut == a[15:8], "R3 R9 high address", portBOut, a[15:8]);
      check(rwOut == !w, "R7 rw line", rwOut, !w);
      if (p < PL) begin
        check(portCOe && portCOut == a[7:0] && !eClkOut, "R4 low address", portCOut, a[7:0]);
      end else if (w) begin
        check(eClkOut && portCOe && portCOut == d, "R5 write data", portCOut, d);
      end else begin
        check(eClkOut && !portCOe, "R6 port released", portCOe, 0);
      end
    end
    pendRead = !w;
    pendVal  = expRd;
    if (w) refMem[idx(a)] = d;
  endtask

  logic [15:0] dirAddr [0:3];

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; refMem[i] = '0; end
    dirAddr[0] = 16'h0000; dirAddr[1] = 16'hFFFF;
    dirAddr[2] = 16'h00FF; dirAddr[3] = 16'hFF00;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    idleCheck("R1 reset state");
    rst = 1'b0;
    @(negedge clk);
    idleCheck("R1 after reset");

    // R10 back-to-back writes then reads
    expEn = 1'b1;
    for (int i = 0; i < 4; i++) busCycle(1'b1, dirAddr[i], 8'h5A ^ 8'(i * 37));
    for (int i = 0; i < 4; i++) busCycle(1'b0, dirAddr[i], 8'h00);
    busCycle(1'b0, 16'h1234, 8'h00);

    // R8 abort a write mid-cycle: memory must stay unchanged
    reqWrite = 1'b1; reqAddr = 16'h0000; reqWdata = 8'hC3;
    pendRead = 0;
    @(negedge clk);
    check(asOut && !rwOut, "R8 abort cycle started", rwOut, 0);
    expEn = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idleCheck("R8 idle after disable");
    end
    expEn = 1'b1;
    busCycle(1'b0, 16'h0000, 8'h00); // expect old value, not C3
    busCycle(1'b0, 16'h00FF, 8'h00);

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [15:0] a;
      a = {8'($urandom_range(0, 255)), 8'($urandom_range(0, 255))};
      if (i % 3 == 0) a = dirAddr[i % 4];
      busCycle(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)));
    end
    busCycle(1'b0, 16'h0000, 8'h00);
    @(negedge clk);
    check(pendRead ? (rdValid && rdData == pendVal) : !rdValid, "R6 last read", rdData, pendVal);
    expEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    idleCheck("R8 final idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule